// File: doc/BRIEF.md
# Compare and Trap Condition Unit

This unit sits beside the integer pipeline and turns operand relations into two kinds of result. The first is a 4-bit condition field, built from a signed compare, an unsigned compare, or a record-form check of a result against zero. The second is a trap request, raised when any relation enabled by a 5-bit condition mask holds between the operands.

Each operation is presented with a one-cycle strobe. It carries two operands, or one operand and a 16-bit immediate, together with the current summary-overflow flag. The outputs are registered and appear on the cycle after the strobe. Whoever owns the condition register copies the field when `fieldValid` pulses. The exception logic takes `trapOut` as a single-cycle request.

Top module: `cmp_trap_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, `fieldOut` is 0 and both `fieldValid` and `trapOut` are low.
- R2: Opcode 2'b00 is the signed compare. One cycle after the strobe, `fieldValid` pulses for one cycle. `fieldOut[3:1]` is 3'b100 when A < B, 3'b010 when A > B and 3'b001 when A == B, with both operands read as two's complement. Exactly one of these three bits is set.
- R3: Opcode 2'b01 is the unsigned compare. It uses the same field coding and timing as R2, with both operands read as unsigned.
- R4: When `useImm` is high, the immediate replaces B. The signed compare sign-extends it. The unsigned compare zero-extends it.
- R5: Opcode 2'b10 is the record form. It compares A, signed, against zero with the coding of R2. `opB` and the immediate have no effect on it.
- R6: For opcodes 2'b00, 2'b01 and 2'b10, `fieldOut[0]` equals the `soIn` value sampled with the strobe.
- R7: Opcode 2'b11 is the trap. `trapOut` pulses one cycle after the strobe when at least one enabled relation holds. Mask bit 4 enables signed less-than, bit 3 signed greater-than, bit 2 equal, bit 1 unsigned less-than and bit 0 unsigned greater-than.
- R8: In a trap with `useImm` high, the sign-extended immediate is B for both the signed and the unsigned relations.
- R9: A trap with a mask of zero never raises `trapOut`.
- R10: A trap operation leaves `fieldOut` unchanged and does not pulse `fieldValid`. A compare or record operation never raises `trapOut`.
- R11: In a cycle after which no strobe was given, `fieldValid` and `trapOut` are low and `fieldOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| opcode | input | 2 | 00 signed compare, 01 unsigned compare, 10 record form, 11 trap |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| immVal | input | 16 | Immediate operand |
| useImm | input | 1 | Use the immediate in place of B |
| soIn | input | 1 | Summary-overflow flag |
| trapMask | input | 5 | Trap condition mask |
| fieldValid | output | 1 | Condition field updated this cycle |
| fieldOut | output | 4 | Condition field {lt, gt, eq, so} |
| trapOut | output | 1 | Trap request pulse |

## Verification
The assertions assume that reset is applied for at least one clock and that `opcode` and the operands are known whenever `inValid` is high. The bench drives every input at the falling edge and holds it for a full cycle, so each strobe and its operands are sampled together at one rising edge. The stimulus mixes directed corner operands with random strobes and idle gaps. The corner operands are zero, all ones, the most negative value and immediates with bit 15 set. Together these give both back-to-back operations and holding periods.

// File: rtl/cmp_trap_pkg.sv
package cmp_trap_pkg;
  typedef enum logic [1:0] {
    OP_SCMP  = 2'b00,
    OP_UCMP  = 2'b01,
    OP_REC   = 2'b10,
    OP_TRAP  = 2'b11
  } cmpOp_e;

  localparam int MASK_BITS  = 5;
  localparam int FIELD_BITS = 4;

  typedef struct packed {
    logic loadField;
    logic evalTrap;
    logic unsignedRel;
    logic zeroExtImm;
    logic againstZero;
    logic takeImm;
  } cmpStrobe_t;
endpackage

// File: rtl/cmp_trap_ctrl.sv
module cmp_trap_ctrl
  import cmp_trap_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opcode,
  input  logic       useImm,
  output cmpStrobe_t stb
);
  cmpOp_e op;

  always_comb begin
    op = cmpOp_e'(opcode);
    stb.loadField   = inValid && (op != OP_TRAP);
    stb.evalTrap    = inValid && (op == OP_TRAP);
    stb.unsignedRel = (op == OP_UCMP);
    stb.zeroExtImm  = (op == OP_UCMP);
    stb.againstZero = (op == OP_REC);
    stb.takeImm     = useImm;
  end
endmodule

// File: rtl/cmp_trap_dp.sv
module cmp_trap_dp
  import cmp_trap_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int IMM_WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cmpStrobe_t            stb,
  input  logic [WIDTH-1:0]      opA,
  input  logic [WIDTH-1:0]      opB,
  input  logic [IMM_WIDTH-1:0]  immVal,
  input  logic                  soIn,
  input  logic [MASK_BITS-1:0]  trapMask,
  output logic                  fieldValid,
  output logic [FIELD_BITS-1:0] fieldOut,
  output logic                  trapOut
);
  localparam int EXT = WIDTH - IMM_WIDTH;

  logic [WIDTH-1:0] immExt, rhs;
  logic sLt, sGt, uLt, uGt, isEq, relLt, relGt, trapHit;
  logic [FIELD_BITS-1:0] fieldNext;
  logic [MASK_BITS-1:0]  relVec;

  always_comb begin
    immExt = stb.zeroExtImm ? {{EXT{1'b0}}, immVal}
                            : {{EXT{immVal[IMM_WIDTH-1]}}, immVal};
    if (stb.againstZero)  rhs = '0;
    else if (stb.takeImm) rhs = immExt;
    else                  rhs = opB;
    isEq  = (opA == rhs);
    sLt   = ($signed(opA) < $signed(rhs));
    uLt   = (opA < rhs);
    sGt   = !sLt && !isEq;
    uGt   = !uLt && !isEq;
    relLt = stb.unsignedRel ? uLt : sLt;
    relGt = stb.unsignedRel ? uGt : sGt;
    fieldNext = {relLt, relGt, isEq, soIn};
    relVec  = {sLt, sGt, isEq, uLt, uGt};
    trapHit = |(relVec & trapMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldValid <= 1'b0;
      fieldOut   <= '0;
      trapOut    <= 1'b0;
    end else begin
      fieldValid <= stb.loadField;
      trapOut    <= stb.evalTrap && trapHit;
      if (stb.loadField) fieldOut <= fieldNext;
    end
  end
endmodule

// File: rtl/cmp_trap_unit.sv
module cmp_trap_unit
  import cmp_trap_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int IMM_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           opcode,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [IMM_WIDTH-1:0] immVal,
  input  logic                 useImm,
  input  logic                 soIn,
  input  logic [4:0]           trapMask,
  output logic                 fieldValid,
  output logic [3:0]           fieldOut,
  output logic                 trapOut
);
  cmpStrobe_t stb;

  cmp_trap_ctrl i_ctrl (
    .inValid(inValid), .opcode(opcode), .useImm(useImm), .stb(stb)
  );

  cmp_trap_dp #(.WIDTH(WIDTH), .IMM_WIDTH(IMM_WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opA(opA), .opB(opB),
    .immVal(immVal), .soIn(soIn), .trapMask(trapMask),
    .fieldValid(fieldValid), .fieldOut(fieldOut), .trapOut(trapOut)
  );
endmodule

// File: rtl/cmp_trap_checker.sv
module cmp_trap_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       opcode,
  input logic [WIDTH-1:0] opA,
  input logic             soIn,
  input logic [4:0]       trapMask,
  input logic             fieldValid,
  input logic [3:0]       fieldOut,
  input logic             trapOut
);
  assert_onehot_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    fieldValid |-> ($countones(fieldOut[3:1]) == 1));

  assert_field_after_cmp_R10: assert property (@(posedge clk) disable iff (!rstN)
    fieldValid |-> ($past(inValid) && $past(opcode) != 2'b11));

  assert_so_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    fieldValid |-> (fieldOut[0] == $past(soIn)));

  assert_trap_after_trap_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapOut |-> ($past(inValid) && $past(opcode) == 2'b11));

  assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    trapOut |-> ($past(trapMask) != 5'd0));

  assert_record_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fieldValid && $past(opcode) == 2'b10 && $past(opA) == '0) |-> fieldOut[1]);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !fieldValid |-> $stable(fieldOut));
endmodule

bind cmp_trap_unit cmp_trap_checker #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .opA(opA),
  .soIn(soIn), .trapMask(trapMask), .fieldValid(fieldValid),
  .fieldOut(fieldOut), .trapOut(trapOut)
);

// File: tb/test_cmp_trap_unit.sv
module test_cmp_trap_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] immVal = '0;
  logic useImm = 1'b0, soIn = 1'b0;
  logic [4:0] trapMask = '0;
  logic fieldValid, trapOut;
  logic [3:0] fieldOut;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] expField = 4'd0;
  logic expValid = 1'b0, expTrap = 1'b0;
  string curTag = "R1";

  always #10 clk = ~clk;

  cmp_trap_unit i_cmp_trap_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .immVal(immVal), .useImm(useImm), .soIn(soIn),
    .trapMask(trapMask), .fieldValid(fieldValid), .fieldOut(fieldOut),
    .trapOut(trapOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareOuts();
    check(fieldValid === expValid, curTag, "fieldValid", fieldValid, expValid);
    check(fieldOut === expField, curTag, "fieldOut", fieldOut, expField);
    check(trapOut === expTrap, curTag, "trapOut", trapOut, expTrap);
  endtask

  // Behavioural model: relations computed with wide integers
  task automatic model(input logic v, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic ui,
                       input logic so, input logic [4:0] m);
    longint sa, sb, ua, ub;
    int code;
    bit t;
    sa = longint'($signed(a));
    ua = longint'({32'd0, a});
    if (op == 2'b10) begin sb = 0; ub = 0; end
    else if (ui) begin
      sb = longint'($signed(im));
      ub = (op == 2'b01) ? longint'({48'd0, im}) : longint'({32'd0, 32'($signed(im))});
      if (op == 2'b01) sb = ub;
    end else begin
      sb = longint'($signed(b));
      ub = longint'({32'd0, b});
    end
    expValid = 1'b0;
    expTrap = 1'b0;
    if (!v) return;
    if (op == 2'b11) begin
      t = (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
          (m[1] && ua < ub) || (m[0] && ua > ub);
      expTrap = t;
    end else begin
      if (op == 2'b01) code = (ua < ub) ? 8 : (ua > ub) ? 4 : 2;
      else             code = (sa < sb) ? 8 : (sa > sb) ? 4 : 2;
      expField = 4'(code) | {3'b000, so};
      expValid = 1'b1;
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] im, input logic ui,
                      input logic so, input logic [4:0] m, input string tag);
    @(negedge clk);
    if (done) return;
    compareOuts();
    inValid = v; opcode = op; opA = a; opB = b; immVal = im;
    useImm = ui; soIn = so; trapMask = m;
    model(v, op, a, b, im, ui, so, m);
    curTag = tag;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 6))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7fff_ffff;
      3: return 32'h8000_0000;
      4: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curTag = "R1";
    compareOuts();                       // R1 during reset
    rstN = 1'b1;
    // R1 first cycle after reset: idle step checks it
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 2'b00, 32'hffff_ffff, 32'h1, 0, 0, 0, 0, "R2");      // -1 < 1 signed
    step(1, 2'b01, 32'hffff_ffff, 32'h1, 0, 0, 0, 0, "R3");      // unsigned >
    step(1, 2'b00, 32'h5, 32'h5, 0, 0, 1, 0, "R6");              // eq with so
    step(1, 2'b00, 32'h0, 0, 16'h8000, 1, 0, 0, "R4");           // 0 > -32768
    step(1, 2'b01, 32'h0, 0, 16'h8000, 1, 0, 0, "R4");           // 0 < 0x8000
    step(1, 2'b10, 32'h8000_0000, 32'h1234, 16'h7, 1, 1, 0, "R5");
    step(1, 2'b10, 32'h0, 32'hffff_ffff, 0, 0, 0, 0, "R5");
    step(1, 2'b10, 32'h42, 0, 0, 0, 0, 0, "R5");
    step(0, 2'b00, 32'h1, 32'h2, 0, 0, 1, 0, "R11");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 2'b11, 32'hffff_ffff, 32'h1, 0, 0, 0, 5'b10000, "R7"); // s<
    step(1, 2'b11, 32'hffff_ffff, 32'h1, 0, 0, 0, 5'b00010, "R7"); // u< false
    step(1, 2'b11, 32'hffff_ffff, 32'h1, 0, 0, 0, 5'b00001, "R7"); // u>
    step(1, 2'b11, 32'h9, 32'h9, 0, 0, 0, 5'b00100, "R7");         // eq
    step(1, 2'b11, 32'h9, 32'h9, 0, 0, 0, 5'b00000, "R9");
    step(1, 2'b11, 32'h8000_0000, 32'h7fff_ffff, 0, 0, 0, 0, "R9");
    step(1, 2'b11, 32'h1, 0, 16'hffff, 1, 0, 5'b00010, "R8");      // 1 <u 0xffffffff
    step(1, 2'b11, 32'h1, 0, 16'hffff, 1, 0, 5'b01000, "R8");      // 1 >s -1
    step(1, 2'b11, 32'h0, 32'h0, 0, 0, 1, 5'b11111, "R10");        // field holds
    step(1, 2'b00, 32'h3, 32'h3, 0, 0, 0, 5'b11111, "R10");        // no trap
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      logic ui;
      string tg;
      op = 2'($urandom);
      ui = 1'($urandom);
      case (op)
        2'b00: tg = ui ? "R4" : "R2";
        2'b01: tg = ui ? "R4" : "R3";
        2'b10: tg = "R5";
        default: tg = ui ? "R8" : "R7";
      endcase
      step(1'($urandom_range(0, 3) != 0), op, pick(), pick(), 16'($urandom),
           ui, 1'($urandom), 5'($urandom), tg);
    end
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R11");
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule